// File: doc/BRIEF.md
# Round-Robin Thread Issue Controller with Replay and Target-Cycle Barrier

This block decides, every host clock, whether the thread that owns the current slot sends an instruction into a deep shared pipeline. The slots follow a fixed rotation over up to 64 thread contexts. The controller keeps three bits for each thread: one instruction still in flight, a committed result for the current simulated cycle, and a pending reissue. Because each thread has at most one instruction in flight, the datapath behind it needs no forwarding.

At the far end of the pipeline, the commit stage reports each instruction either as retired or as needing a replay. A replay happens when a long-latency event, such as a host cache miss, has not yet resolved. A replayed instruction is not counted. Its thread simply sends it again on its next slot, and that second issue is marked as a reissue. A simulated-cycle counter steps forward only once every active thread has retired its instruction for the present simulated cycle. All thread contexts therefore stay on the same simulated cycle. Threads that are switched off leave an empty slot and never hold back the counter. A thread that the timing model stalls does not issue, and it does hold back the counter.

Top module: `mt_rr_issue`

## Requirements
- R1: Reset clears the simulated-cycle counter to 0, sets the slot to thread 0, and clears every in-flight, committed and reissue bit. In the first cycle after reset the output shows thread 0 in the slot, with no reissue mark.
- R2: `issue_tid` shows the thread that owns the current slot in every cycle. It steps by one each cycle and wraps from NUM_THREADS-1 to 0, whether or not an issue takes place.
- R3: `issue_valid` is 1 exactly when the slot thread is enabled in `active_mask`, has its `stall_req` bit at 0, has nothing in flight, and has not yet retired for the current simulated cycle.
- R4: A thread has at most one instruction in flight. The in-flight bit is set by an issue and cleared by any commit report for that thread, whether the report is a retire or a replay.
- R5: A commit report with `cmt_replay`=1 does not count as retired. The thread becomes eligible again on its next slot, and that issue has `issue_replay`=1.
- R6: A commit report with `cmt_replay`=0 marks the thread as retired for the current simulated cycle and clears its reissue mark. Its next issue has `issue_replay`=0.
- R7: `tcycle` increments by exactly one in the cycle that follows the cycle in which every enabled thread is marked retired. That same increment clears all retired marks. When `active_mask` is all zero, `tcycle` does not move.
- R8: A thread whose `active_mask` bit is 0 never issues, and its slot stays empty. Its missing retire mark does not hold back `tcycle`.
- R9: An enabled thread whose `stall_req` bit is 1 does not issue. Until the stall is released, it keeps `tcycle` from advancing.
- R10: `tcycle` is TCYC_W bits wide (64 by default) and can be read at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| active_mask | input | NUM_THREADS | Enable bit for each thread context |
| stall_req | input | NUM_THREADS | Stall request from the timing model, one bit per thread |
| cmt_valid | input | 1 | A commit report is present this cycle |
| cmt_tid | input | TID_W | Thread that the commit report refers to |
| cmt_replay | input | 1 | 1: a long-latency event is pending, so reissue; 0: retire |
| issue_valid | output | 1 | The slot thread issues this cycle |
| issue_tid | output | TID_W | Thread that owns the current slot |
| issue_replay | output | 1 | The current issue is a reissue after a replay |
| tcycle | output | TCYC_W | Simulated-cycle counter |

## Verification
The issue outputs are combinational functions of the state registers, the slot pointer and the mask inputs. They are valid in the same cycle as the mask inputs that produce them. A commit report presented before a clock edge changes the in-flight, retired and reissue bits at that edge. The counter moves one edge after the last retire mark is set. The bench drives inputs on the falling edge and samples one time unit later. At each sample it compares the outputs with a model that advances its state by exactly the same one-edge rule, so the slot, the issue decision, the reissue mark and the counter are all compared in every cycle. A fixed-latency pipe in the bench returns commit reports a set number of cycles after each issue.

// File: rtl/mt_issue_pkg.sv
package mt_issue_pkg;

   // What the commit stage reported for a thread in a given cycle.
   typedef enum logic [1:0] {
      CMT_NONE   = 2'd0,
      CMT_RETIRE = 2'd1,
      CMT_REPLAY = 2'd2
   } cmt_kind_e;

   function automatic cmt_kind_e classify_commit(input logic valid, input logic replay);
      if (!valid)      return CMT_NONE;
      else if (replay) return CMT_REPLAY;
      else             return CMT_RETIRE;
   endfunction

endpackage

// File: rtl/mti_slot_ctr.sv
module mti_slot_ctr #(
   parameter int NUM_THREADS = 64,
   localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [TID_W-1:0] slot
);

   localparam logic [TID_W-1:0] LAST = TID_W'(NUM_THREADS - 1);

   generate
      if ((1 << TID_W) == NUM_THREADS) begin : g_pow2
         // The natural binary wrap gives the rotation.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot <= '0;
            else        slot <= slot + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             slot <= '0;
            else if (slot == LAST)  slot <= '0;
            else                    slot <= slot + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/mti_thread_state.sv
module mti_thread_state
   import mt_issue_pkg::*;
#(
   parameter int NUM_THREADS = 64,
   localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   issue_fire,
   input  logic [TID_W-1:0]       issue_tid,
   input  cmt_kind_e              cmt_kind,
   input  logic [TID_W-1:0]       cmt_tid,
   input  logic                   advance,
   output logic [NUM_THREADS-1:0] inflight,
   output logic [NUM_THREADS-1:0] retired,
   output logic [NUM_THREADS-1:0] reissue
);

   generate
      for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
         logic hit_issue;
         logic hit_cmt;
         assign hit_issue = issue_fire && (issue_tid == TID_W'(t));
         assign hit_cmt   = (cmt_kind != CMT_NONE) && (cmt_tid == TID_W'(t));

         // The in-flight bit covers one instruction from issue until commit.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         inflight[t] <= 1'b0;
            else if (hit_issue) inflight[t] <= 1'b1;
            else if (hit_cmt)   inflight[t] <= 1'b0;
         end

         // The retired mark holds for one simulated cycle; the barrier clears it.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       retired[t] <= 1'b0;
            else if (advance) retired[t] <= 1'b0;
            else if (hit_cmt && cmt_kind == CMT_RETIRE) retired[t] <= 1'b1;
         end

         // A replay report sets the reissue mark; a later retire clears it.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) reissue[t] <= 1'b0;
            else if (hit_cmt) reissue[t] <= (cmt_kind == CMT_REPLAY);
         end
      end
   endgenerate

endmodule

// File: rtl/mti_barrier.sv
module mti_barrier #(
   parameter int NUM_THREADS = 64,
   parameter int TCYC_W      = 64
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_THREADS-1:0] active_mask,
   input  logic [NUM_THREADS-1:0] retired,
   output logic                   advance,
   output logic [TCYC_W-1:0]      tcycle
);

   logic all_retired;
   logic any_active;

   always_comb begin
      all_retired = &(retired | ~active_mask);
      any_active  = |active_mask;
      advance     = all_retired && any_active;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tcycle <= '0;
      else if (advance) tcycle <= tcycle + 1'b1;
   end

endmodule

// File: rtl/mt_rr_issue.sv
module mt_rr_issue
   import mt_issue_pkg::*;
#(
   parameter int NUM_THREADS = 64,
   parameter int TCYC_W      = 64,
   localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_THREADS-1:0] active_mask,
   input  logic [NUM_THREADS-1:0] stall_req,
   input  logic                   cmt_valid,
   input  logic [TID_W-1:0]       cmt_tid,
   input  logic                   cmt_replay,
   output logic                   issue_valid,
   output logic [TID_W-1:0]       issue_tid,
   output logic                   issue_replay,
   output logic [TCYC_W-1:0]      tcycle
);

   generate
      if (NUM_THREADS < 2 || NUM_THREADS > 1024) begin : g_bad_threads
         $error("mt_rr_issue: NUM_THREADS must lie in 2..1024");
      end
      if (TCYC_W < 8 || TCYC_W > 64) begin : g_bad_tcyc
         $error("mt_rr_issue: TCYC_W must lie in 8..64");
      end
   endgenerate

   logic [TID_W-1:0]       slot;
   logic [NUM_THREADS-1:0] inflight;
   logic [NUM_THREADS-1:0] retired;
   logic [NUM_THREADS-1:0] reissue;
   logic                   advance;
   cmt_kind_e              cmt_kind;

   mti_slot_ctr #(.NUM_THREADS(NUM_THREADS)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .slot  (slot)
   );

   always_comb begin
      cmt_kind     = classify_commit(cmt_valid, cmt_replay);
      issue_tid    = slot;
      issue_valid  = active_mask[slot] && !stall_req[slot] &&
                     !inflight[slot] && !retired[slot];
      issue_replay = issue_valid && reissue[slot];
   end

   mti_thread_state #(.NUM_THREADS(NUM_THREADS)) u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue_fire (issue_valid),
      .issue_tid  (slot),
      .cmt_kind   (cmt_kind),
      .cmt_tid    (cmt_tid),
      .advance    (advance),
      .inflight   (inflight),
      .retired    (retired),
      .reissue    (reissue)
   );

   mti_barrier #(.NUM_THREADS(NUM_THREADS), .TCYC_W(TCYC_W)) u_barrier (
      .clk         (clk),
      .rst_n       (rst_n),
      .active_mask (active_mask),
      .retired     (retired),
      .advance     (advance),
      .tcycle      (tcycle)
   );

endmodule

// File: rtl/mt_rr_issue_chk.sv
module mt_rr_issue_chk #(
   parameter int NUM_THREADS = 64,
   parameter int TCYC_W      = 64,
   localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_THREADS-1:0] active_mask,
   input logic [NUM_THREADS-1:0] stall_req,
   input logic                   cmt_valid,
   input logic [TID_W-1:0]       cmt_tid,
   input logic                   cmt_replay,
   input logic                   issue_valid,
   input logic [TID_W-1:0]       issue_tid,
   input logic                   issue_replay,
   input logic [TCYC_W-1:0]      tcycle
);

   localparam logic [TID_W-1:0] LAST = TID_W'(NUM_THREADS - 1);

   logic                   seen;
   logic [NUM_THREADS-1:0] sh_out;
   logic [NUM_THREADS-1:0] sh_rp;

   // Shadow state rebuilt from port traffic alone.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen   <= 1'b0;
         sh_out <= '0;
         sh_rp  <= '0;
      end else begin
         seen <= 1'b1;
         if (issue_valid) sh_out[issue_tid] <= 1'b1;
         if (cmt_valid) begin
            sh_out[cmt_tid] <= 1'b0;
            sh_rp[cmt_tid]  <= cmt_replay;
         end
      end
   end

   a_r2_slot_rotates: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> issue_tid == (($past(issue_tid) == LAST) ? '0 : $past(issue_tid) + 1'b1));

   a_r4_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> !sh_out[issue_tid]);

   a_r5_reissue_mark: assert property (@(posedge clk) disable iff (!rst_n)
      issue_replay |-> (issue_valid && sh_rp[issue_tid]));

   a_r7_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> (tcycle == $past(tcycle) || tcycle == $past(tcycle) + 1'b1));

   a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && active_mask == '0 && $past(active_mask) == '0) |=> $stable(tcycle));

   a_r8_inactive_bubble: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> active_mask[issue_tid]);

   a_r9_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> !stall_req[issue_tid]);

endmodule

bind mt_rr_issue mt_rr_issue_chk #(.NUM_THREADS(NUM_THREADS), .TCYC_W(TCYC_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .active_mask  (active_mask),
   .stall_req    (stall_req),
   .cmt_valid    (cmt_valid),
   .cmt_tid      (cmt_tid),
   .cmt_replay   (cmt_replay),
   .issue_valid  (issue_valid),
   .issue_tid    (issue_tid),
   .issue_replay (issue_replay),
   .tcycle       (tcycle)
);

// File: tb/mt_rr_issue_bench.sv
`timescale 1ns/1ps
module mt_rr_issue_bench;

   localparam int N   = 8;
   localparam int TW  = 3;
   localparam int CW  = 64;
   localparam int LAT = 5;

   // Each entry: active mask, replay mask, simulated cycles to run.
   localparam int NVEC = 5;
   localparam logic [23:0] VEC [0:NVEC-1] = '{
      {8'hFF, 8'h00, 8'd4},
      {8'h0F, 8'h01, 8'd3},
      {8'hA5, 8'hA5, 8'd3},
      {8'h80, 8'h80, 8'd5},
      {8'h7E, 8'h18, 8'd2}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  active_mask = '0;
   logic [N-1:0]  stall_req = '0;
   logic          cmt_valid = 1'b0;
   logic [TW-1:0] cmt_tid = '0;
   logic          cmt_replay = 1'b0;
   logic          issue_valid;
   logic [TW-1:0] issue_tid;
   logic          issue_replay;
   logic [CW-1:0] tcycle;

   always #5 clk = ~clk;

   mt_rr_issue #(.NUM_THREADS(N), .TCYC_W(CW)) u_mt_rr_issue (
      .clk(clk), .rst_n(rst_n), .active_mask(active_mask), .stall_req(stall_req),
      .cmt_valid(cmt_valid), .cmt_tid(cmt_tid), .cmt_replay(cmt_replay),
      .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_replay(issue_replay),
      .tcycle(tcycle)
   );

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit finished = 0;

   // Model state
   logic [N-1:0]  m_out, m_done, m_rpend, m_tried;
   logic [N-1:0]  rmask;
   logic [TW-1:0] exp_slot;
   logic [CW-1:0] exp_tc;
   logic          p_v [0:LAT-1];
   logic [TW-1:0] p_t [0:LAT-1];
   int            n_good, n_rep, n_issue_stalled;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset(input logic [N-1:0] act, input logic [N-1:0] rm);
      rst_n = 1'b0;
      cmt_valid = 1'b0; cmt_tid = '0; cmt_replay = 1'b0;
      active_mask = '0; stall_req = '0;
      m_out = '0; m_done = '0; m_rpend = '0; m_tried = '0;
      exp_slot = '0; exp_tc = '0; n_good = 0; n_rep = 0; n_issue_stalled = 0;
      rmask = rm;
      for (int i = 0; i < LAT; i++) begin p_v[i] = 1'b0; p_t[i] = '0; end
      repeat (3) @(negedge clk);
      #1;
      check(tcycle == '0, "R1 tcycle in reset", tcycle, 0);
      check(issue_tid == '0, "R1 slot in reset", issue_tid, 0);
      check(issue_valid == 1'b0, "R1 no issue with empty mask", issue_valid, 0);
      active_mask = act;
      rst_n = 1'b1;
   endtask

   // One cycle: called just after a falling edge.
   task automatic tick();
      logic exp_issue, adv, cv, cr;
      logic [TW-1:0] ct;
      #1;
      exp_issue = active_mask[exp_slot] && !stall_req[exp_slot] &&
                  !m_out[exp_slot] && !m_done[exp_slot];
      check(issue_tid == exp_slot, "R2 slot rotation", issue_tid, exp_slot);
      check(tcycle == exp_tc, "R7 counter", tcycle, exp_tc);
      check(issue_valid == exp_issue, "R3 issue decision", issue_valid, exp_issue);
      if (issue_valid && exp_issue)
         check(issue_replay == m_rpend[exp_slot], "R5 R6 reissue mark",
               issue_replay, m_rpend[exp_slot]);
      if (issue_valid && stall_req[issue_tid]) n_issue_stalled++;
      // Commit report leaving the bench pipe
      cv = p_v[LAT-1]; ct = p_t[LAT-1];
      cr = cv && rmask[ct] && !m_tried[ct];
      cmt_valid = cv; cmt_tid = ct; cmt_replay = cr;
      // State after the next rising edge
      adv = (&(m_done | ~active_mask)) && (|active_mask);
      if (issue_valid) m_out[issue_tid] = 1'b1;
      if (cv) begin
         m_out[ct] = 1'b0;
         m_rpend[ct] = cr;
         if (cr) n_rep++; else n_good++;
      end
      if (adv) begin
         m_done = '0; m_tried = '0;
      end else if (cv) begin
         m_tried[ct] = 1'b1;
         if (!cr) m_done[ct] = 1'b1;
      end
      exp_tc = exp_tc + CW'(adv);
      exp_slot = (exp_slot == TW'(N - 1)) ? '0 : exp_slot + 1'b1;
      for (int i = LAT - 1; i > 0; i--) begin p_v[i] = p_v[i-1]; p_t[i] = p_t[i-1]; end
      p_v[0] = issue_valid; p_t[0] = issue_tid;
      @(negedge clk);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !finished) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);

      // Vector table: full runs to a target simulated cycle
      for (int v = 0; v < NVEC; v++) begin
         logic [N-1:0] act;
         int ncyc, guard;
         act = VEC[v][23:16];
         ncyc = int'(VEC[v][7:0]);
         do_reset(act, VEC[v][15:8]);
         // R1: state right after reset release
         #1;
         check(issue_tid == '0 && issue_replay == 1'b0, "R1 first slot after reset",
               issue_tid, 0);
         guard = 0;
         while (tcycle < CW'(ncyc) && guard < 600) begin tick(); guard++; end
         check(tcycle == CW'(ncyc), "R7 R10 target cycle reached", tcycle, ncyc);
         check(n_good == ncyc * $countones(act), "R6 R8 retire count",
               n_good, ncyc * $countones(act));
         check(n_rep == ncyc * $countones(act & VEC[v][15:8]), "R5 replay count",
               n_rep, ncyc * $countones(act & VEC[v][15:8]));
      end

      // R9: a stalled thread holds the barrier, then release
      do_reset(8'h0F, 8'h00);
      stall_req = 8'h04;
      repeat (40) tick();
      check(tcycle == '0, "R9 barrier held by stall", tcycle, 0);
      check(n_issue_stalled == 0, "R9 stalled thread issued", n_issue_stalled, 0);
      stall_req = '0;
      begin
         int g = 0;
         while (tcycle < 2 && g < 200) begin tick(); g++; end
      end
      check(tcycle == 64'd2, "R9 advance after release", tcycle, 2);

      // R7: empty mask, counter frozen and no issue
      do_reset(8'h00, 8'h00);
      repeat (20) tick();
      check(tcycle == '0, "R7 idle counter", tcycle, 0);

      // R8: a stalled straggler switched off no longer holds the barrier
      do_reset(8'hFF, 8'h00);
      stall_req = 8'h01;
      repeat (30) tick();
      check(tcycle == '0, "R8 straggler holds while enabled", tcycle, 0);
      active_mask = 8'hFE;
      begin
         int g = 0;
         while (tcycle < 3 && g < 200) begin tick(); g++; end
      end
      check(tcycle == 64'd3, "R8 disabled thread ignored", tcycle, 3);
      check(n_good == 21, "R8 retires of seven threads", n_good, 21);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule